// File: doc/BRIEF.md
# Serial Clock Divider with Launch and Sample Strobes

This block derives the serial clock for a master-side serial port from the system clock. Two counters are chained. A prescaler divides the system clock by `pre_div + 1`. A phase counter then divides that rate by `div_last + 1`. A separate `high_last` setting fixes how long the clock stays away from its rest level in each period. For a duty cycle near 50%, set `high_last` to floor((div_last + 1) / 2) - 1. A pass-through mode routes the system clock straight to the pin, and no counter is used in that mode.

A transaction sequencer raises `run` to request clock periods. At the first edge of each period the block pulses `launch` for one cycle, and at the edge back to the rest level it pulses `sample` for one cycle. The sequencer uses these pulses to shift data out and to capture data in. When `run` drops, the period in progress runs to its end and the clock then rests. A rest-level input selects whether the clock rests high or low. A separate input stops the block from driving the pin.

Top module: `sck_divider`

## Requirements
- R1: In divided mode, with `run` held high, consecutive `launch` pulses are exactly (pre_div+1)*(div_last+1) system cycles apart.
- R2: In each divided period, `sck_o` is away from its rest level for (high_last+1)*(pre_div+1) cycles, starting in the cycle in which `launch` is high. The rest of the period is at the rest level.
- R3: In divided mode, `launch` is high for one cycle at the start of each period and `sample` is high for exactly one cycle per period, at the return to the rest level. The two are never high together.
- R4: While the block is not busy and not in pass-through, `sck_o` equals `idle_hi` (1 = rests high, 0 = rests low).
- R5: When `run` drops during a period, that period completes to full length, no further `launch` follows, `busy` falls, and `sck_o` returns to the rest level.
- R6: With `bypass` = 1 and `run` = 1, `sck_o` equals `clk`, and `launch`, `sample` and `busy` are all 1. The divider settings have no effect. With `run` = 0, `sck_o` is at the rest level.
- R7: With `out_dis` = 1, `sck_oe` is 0 and `sck_o` stays at the rest level, while `launch` and `sample` keep their normal timing.
- R8: The counters are cleared while the block is idle, so the first period after `run` rises is full length. Its first `launch` appears one cycle after the first rising edge that sees `run` high.
- R9: After reset, `busy`, `launch` and `sample` are 0, `sck_oe` is 1 and `sck_o` is at the rest level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Sequencer request for clock periods |
| pre_div | input | PRE_W | Prescaler terminal count (divide by value+1) |
| div_last | input | DIV_W | Last phase index of a period (divide by value+1, at least 1) |
| high_last | input | DIV_W | Last phase index away from the rest level (less than div_last) |
| bypass | input | 1 | 1: route the system clock to the pin |
| idle_hi | input | 1 | Rest level of the serial clock |
| out_dis | input | 1 | 1: stop driving the serial clock pin |
| sck_o | output | 1 | Serial clock value |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| launch | output | 1 | One-cycle pulse at the leading edge of a period |
| sample | output | 1 | One-cycle pulse at the trailing edge of a period |
| busy | output | 1 | A period is in progress, or pass-through is running |

## Verification
The case that is hardest to reach from the ports is `run` dropping inside a period whose prescaler is large. The clock must then finish the whole period without cutting the pulse short, and it must not start another. The stimulus drops `run` in the same cycle that a `launch` is seen. It then counts `busy` cycles up to the fall, so the count must equal one full period even when the prescaler is at its maximum. The first period after each start is measured separately from the steady-state period, so a counter that is not cleared while idle shows up as a short first period.

// File: rtl/sckgen_pkg.sv
package sckgen_pkg;
   typedef struct packed {
      logic launch;
      logic sample;
   } sck_strobe_t;

   localparam int unsigned SCKGEN_PRE_W_MAX = 8;
   localparam int unsigned SCKGEN_DIV_W_MAX = 12;
endpackage

// File: rtl/sckgen_prescale.sv
module sckgen_prescale #(
   parameter int unsigned PRE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             count_en,
   input  logic [PRE_W-1:0] limit,
   output logic             tick
);
   logic [PRE_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!count_en)      cnt_q <= '0;
      else if (cnt_q == limit) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   assign tick = count_en && (cnt_q == limit);

   // R1
   pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_en |-> (cnt_q <= limit));
endmodule

// File: rtl/sckgen_phase.sv
module sckgen_phase
   import sckgen_pkg::*;
#(
   parameter int unsigned DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold_off,
   input  logic             tick,
   input  logic [DIV_W-1:0] div_last,
   input  logic [DIV_W-1:0] high_last,
   output logic             active,
   output logic             away,
   output sck_strobe_t      strobe
);
   logic [DIV_W-1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         away   <= 1'b0;
         ph_q   <= '0;
         strobe <= '0;
      end else begin
         strobe <= '0;
         if (!active) begin
            if (run && !hold_off) begin
               active        <= 1'b1;
               ph_q          <= '0;
               away          <= 1'b1;
               strobe.launch <= 1'b1;
            end
         end else if (tick) begin
            if (ph_q == div_last) begin
               ph_q <= '0;
               if (run) begin
                  away          <= 1'b1;
                  strobe.launch <= 1'b1;
               end else begin
                  active <= 1'b0;
                  away   <= 1'b0;
               end
            end else begin
               ph_q <= ph_q + 1'b1;
               if (ph_q == high_last) begin
                  away          <= 1'b0;
                  strobe.sample <= 1'b1;
               end
            end
         end
      end
   end

   // R3
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(strobe.launch && strobe.sample));
   // R3
   lead_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(away) |-> strobe.launch);
   // R4
   idle_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !away);
   // R5
   stop_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> ($past(tick) && !$past(run)));
   // R1
   cfg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (div_last != '0 && high_last < div_last));
endmodule

// File: rtl/sckgen_drive.sv
module sckgen_drive
   import sckgen_pkg::*;
#(
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic        clk,
   input  logic        run,
   input  logic        bypass,
   input  logic        idle_hi,
   input  logic        out_dis,
   input  logic        active,
   input  logic        away,
   input  sck_strobe_t div_strobe,
   output logic        pass_on,
   output logic        sck_o,
   output logic        sck_oe,
   output sck_strobe_t strobe
);
   if (BYPASS_EN) begin : g_pass
      assign pass_on = bypass && run;
   end else begin : g_nopass
      assign pass_on = 1'b0;
   end

   always_comb begin
      if (out_dis)      sck_o = idle_hi;
      else if (pass_on) sck_o = clk;
      else              sck_o = away ^ idle_hi;
      sck_oe = !out_dis;
      strobe = pass_on ? '{launch: 1'b1, sample: 1'b1} : div_strobe;
   end

   // R6
   pass_excl_chk: assert property (@(posedge clk)
      !(pass_on && active && !$past(pass_on)));
endmodule

// File: rtl/sck_divider.sv
module sck_divider
   import sckgen_pkg::*;
#(
   parameter int unsigned PRE_W     = 4,
   parameter int unsigned DIV_W     = 6,
   parameter bit          BYPASS_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] pre_div,
   input  logic [DIV_W-1:0] div_last,
   input  logic [DIV_W-1:0] high_last,
   input  logic             bypass,
   input  logic             idle_hi,
   input  logic             out_dis,
   output logic             sck_o,
   output logic             sck_oe,
   output logic             launch,
   output logic             sample,
   output logic             busy
);
   if (PRE_W < 1 || PRE_W > SCKGEN_PRE_W_MAX) begin : g_bad_pre
      $error("sck_divider: PRE_W out of range");
   end
   if (DIV_W < 2 || DIV_W > SCKGEN_DIV_W_MAX) begin : g_bad_div
      $error("sck_divider: DIV_W out of range");
   end

   logic        tick, active, away, pass_on;
   sck_strobe_t div_strobe, out_strobe;

   sckgen_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .count_en(active),
      .limit(pre_div), .tick(tick));

   sckgen_phase #(.DIV_W(DIV_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .run(run), .hold_off(BYPASS_EN && bypass),
      .tick(tick), .div_last(div_last), .high_last(high_last),
      .active(active), .away(away), .strobe(div_strobe));

   sckgen_drive #(.BYPASS_EN(BYPASS_EN)) u_drive (
      .clk(clk), .run(run), .bypass(bypass), .idle_hi(idle_hi),
      .out_dis(out_dis), .active(active), .away(away),
      .div_strobe(div_strobe), .pass_on(pass_on),
      .sck_o(sck_o), .sck_oe(sck_oe), .strobe(out_strobe));

   assign launch = out_strobe.launch;
   assign sample = out_strobe.sample;
   assign busy   = active || pass_on;

   // R5
   rest_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (sck_o == idle_hi));
endmodule

// File: tb/sck_divider_test.sv
module sck_divider_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic [3:0] pre_div = '0;
   logic [5:0] div_last = 6'd1;
   logic [5:0] high_last = '0;
   logic       bypass = 1'b0, idle_hi = 1'b0, out_dis = 1'b0;
   logic       sck_o, sck_oe, launch, sample, busy;

   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   sck_divider uut (.*);

   // {idle_hi, pre_div, div_last}
   localparam int NV = 6;
   localparam logic [10:0] VEC [NV] = '{
      {1'b0, 4'd0,  6'd1},
      {1'b0, 4'd0,  6'd2},
      {1'b1, 4'd3,  6'd5},
      {1'b0, 4'd1,  6'd7},
      {1'b1, 4'd15, 6'd3},
      {1'b0, 4'd2,  6'd63}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_launch(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (launch) begin seen = 1'b1; break; end
      end
   endtask

   // counts one period from a launch negedge to the next launch
   task automatic measure(output int cyc, output int away_n, output int smp);
      cyc = 0; away_n = 0; smp = 0;
      do begin
         cyc++;
         if (sck_o != idle_hi) away_n++;
         if (sample) smp++;
         @(negedge clk);
      end while (!launch && cyc < 5000);
   endtask

   initial begin
      #2000000;
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      bit seen;
      int cyc, aw, smp, per, hexp, nl;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(busy == 0 && launch == 0 && sample == 0, "R9 strobes/busy", {busy, launch, sample}, 0);
      chk(sck_oe == 1 && sck_o == 0, "R9 pin", {sck_oe, sck_o}, 2);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         {idle_hi, pre_div, div_last} = VEC[v];
         high_last = 6'((int'(div_last) + 1) / 2 - 1);
         per  = (int'(pre_div) + 1) * (int'(div_last) + 1);
         hexp = (int'(high_last) + 1) * (int'(pre_div) + 1);
         @(negedge clk);
         // R4 rest level before start
         chk(sck_o == idle_hi && !busy, "R4 rest", sck_o, idle_hi);
         run = 1'b1;
         @(negedge clk);
         // R8 launch one cycle after start edge
         chk(launch == 1, "R8 first launch", launch, 1);
         measure(cyc, aw, smp);
         chk(cyc == per, "R8 first period", cyc, per);
         chk(aw == hexp, "R2 away time", aw, hexp);
         chk(smp == 1, "R3 sample count", smp, 1);
         measure(cyc, aw, smp);
         chk(cyc == per, "R1 period", cyc, per);
         // now at a launch negedge: drop run mid-period
         run = 1'b0;
         cyc = 0; nl = 0;
         while (busy && cyc < 5000) begin
            cyc++;
            @(negedge clk);
            if (launch) nl++;
         end
         chk(cyc == per, "R5 final period length", cyc, per);
         chk(nl == 0, "R5 no extra launch", nl, 0);
         chk(sck_o == idle_hi, "R5 rest after stop", sck_o, idle_hi);
      end

      // R7 output disable
      idle_hi = 1'b1; pre_div = 4'd1; div_last = 6'd3; high_last = 6'd1;
      out_dis = 1'b1;
      @(negedge clk);
      run = 1'b1;
      wait_launch(seen);
      chk(seen, "R7 launch kept", seen, 1);
      measure(cyc, aw, smp);
      chk(sck_oe == 0, "R7 oe low", sck_oe, 0);
      chk(aw == 0, "R7 pin at rest", aw, 0);
      chk(smp == 1 && cyc == 8, "R7 strobe timing", cyc, 8);
      run = 1'b0;
      while (busy) @(negedge clk);
      out_dis = 1'b0;

      // R6 pass-through, with dividers at odd values
      bypass = 1'b1; idle_hi = 1'b0; pre_div = 4'd9; div_last = 6'd5;
      @(negedge clk);
      chk(sck_o == 0 && !busy, "R6 idle in pass-through", sck_o, 0);
      run = 1'b1;
      #1;
      chk(launch && sample && busy, "R6 strobes", {launch, sample, busy}, 7);
      chk(sck_o == clk, "R6 low phase", sck_o, clk);
      @(posedge clk); #2;
      chk(sck_o == 1, "R6 high phase", sck_o, 1);
      @(negedge clk);
      run = 1'b0;
      #1;
      chk(sck_o == 0 && !busy, "R6 stop", sck_o, 0);
      bypass = 1'b0;

      // R4 rest high without run
      idle_hi = 1'b1;
      repeat (3) @(negedge clk);
      chk(sck_o == 1 && !launch, "R4 rest high", sck_o, 1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule